// File: doc/BRIEF.md
# Feed-protected clock configuration controller

This block holds the settings of an on-chip clock synthesizer and changes its output clock between the reference input and the synthesized clock. Software writes a multiplier/post-divider word and an enable/connect word into shadow copies. Neither copy reaches the active settings until a two-write unlock pattern arrives at the feed address. Any other write in between cancels the pattern.

A lock model stands in for the analog loop. It raises lock a programmable number of reference cycles after the synthesizer is enabled, and it drops lock again when a different multiplier or divider is committed. The synthesized clock is routed to `sys_clk_o` only while enable, connect and lock are all true. The change of source, in either direction, goes through a two-flop handshake in each clock domain, and each gate closes on its own clock's falling edge.

A separately written ratio code drives a peripheral-bus clock-enable strobe in the reference domain. All register accesses are single-cycle writes. Reads are combinational from the current address.

Top module: `clk_cfg_ctrl`

## Requirements
- R1: After reset the active multiplier code and divider code are 0, enable, connect and lock are 0, and the reference clock is selected. The strobe ratio is 1, so `pclk_en_o` is high in every cycle. The lock delay register holds `LOCK_DLY_RST`.
- R2: A write to address 0 (configuration) or address 1 (control) changes only a shadow copy. `mult_o`, `pdiv_o`, `syn_en_o` and the read-back of addresses 0 and 1 keep showing the active values.
- R3: Address 0 has the multiplier code in bits [4:0] (multiplier = code+1) and the divider code in bits [6:5] (codes 0..3 give 1, 2, 4, 8). Address 1 has enable in bit 0 and connect in bit 1. A write of 0xAA to address 2, followed by a write of 0x55 to address 2 as the next bus write, copies both shadows into the active registers at that clock edge. Idle cycles between the two writes are allowed.
- R4: The pending unlock is cancelled, and nothing is committed, when the write after 0xAA goes to another address or carries any other value. A 0x55 that does not follow 0xAA also commits nothing.
- R5: With lock delay D written at address 5, lock rises D reference cycles after the commit edge that turns enable on (D = 0 behaves as 1). Lock is never high while enable is low, and it falls at the commit edge that clears enable.
- R6: A commit that changes the multiplier or divider code drops lock at that edge and restarts the count. A commit with an unchanged configuration keeps lock.
- R7: The synthesized clock is requested only while enable, connect and lock are all active. Otherwise the reference clock is requested. `clk_sel_o` follows the request within 10 reference cycles, and `sys_clk_o` then runs at the selected clock's rate.
- R8: `sys_clk_o` never shows a high or low phase shorter than the shorter half period of the two input clocks, and the two source gates are never open together.
- R9: Address 4 bits [1:0] set the strobe ratio: code 0 gives 1, code 1 gives 2, codes 2 and 3 give 4. `pclk_en_o` is high in the cycle right after the write and then once every ratio cycles.
- R10: Address 3 reads {4'b0, connect, enable, clk_sel, lock}. Addresses 4 and 5 read back their values. Address 2 and unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk_i | input | 1 | Reference clock; clocks the register interface |
| syn_clk_i | input | 1 | Synthesized clock from the oscillator model |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_we_i | input | 1 | Write strobe, one write per cycle |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for the current address |
| mult_o | output | 5 | Active multiplier code |
| pdiv_o | output | 2 | Active post-divider code |
| syn_en_o | output | 1 | Active enable to the synthesizer |
| lock_o | output | 1 | Lock indication from the lock model |
| clk_sel_o | output | 1 | 1 while the synthesized clock drives sys_clk_o |
| sys_clk_o | output | 1 | Glitch-free system clock |
| pclk_en_o | output | 1 | Peripheral-bus clock-enable strobe |

## Verification
The assertions assume that the bus inputs change only away from the rising edge of the reference clock. They also assume that the two clocks are free-running and never have coinciding edges, and that the gates are sampled where neither domain is switching. The bench drives every bus write at the falling reference edge. It runs the synthesized clock at a period of 6 ns with a 1.3 ns offset, so its falling edges never meet a rising reference edge. Lock delays are kept small so that lock, drop and reselection all happen within short windows the bench can watch.

// File: rtl/clk_cfg_pkg.sv
`timescale 1ns/1ps
package clk_cfg_pkg;
  localparam int MULT_W = 5;
  localparam int PDIV_W = 2;
  localparam int CFG_W  = MULT_W + PDIV_W;
  localparam int ADDR_W = 3;
  localparam int APB_W  = 2;
  localparam int CNT_MAX_W = 2;

  localparam logic [ADDR_W-1:0] A_CFG  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd1;
  localparam logic [ADDR_W-1:0] A_FEED = 3'd2;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd3;
  localparam logic [ADDR_W-1:0] A_APB  = 3'd4;
  localparam logic [ADDR_W-1:0] A_LDLY = 3'd5;

  localparam logic [7:0] FEED_KEY_A = 8'hAA;
  localparam logic [7:0] FEED_KEY_B = 8'h55;

  typedef struct packed {
    logic [PDIV_W-1:0] pdiv;
    logic [MULT_W-1:0] mult;
  } cfg_t;

  typedef struct packed {
    logic conn;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/clk_cfg_regs.sv
`timescale 1ns/1ps
module clk_cfg_regs
  import clk_cfg_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int LOCK_W       = 8,
  parameter int LOCK_DLY_RST = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              lock_i,
  input  logic              sel_i,
  output logic [DATA_W-1:0] rdata_o,
  output cfg_t              cfg_o,
  output ctrl_t             ctrl_o,
  output logic              drop_o,
  output logic [APB_W-1:0]  apb_code_o,
  output logic              apb_wr_o,
  output logic [LOCK_W-1:0] lock_dly_o
);
  cfg_t  cfg_sh;
  ctrl_t ctrl_sh;
  logic  armed, wr_feed, key_a, key_b, commit;

  assign wr_feed  = we_i && (addr_i == A_FEED);
  assign key_a    = (wdata_i == DATA_W'(FEED_KEY_A));
  assign key_b    = (wdata_i == DATA_W'(FEED_KEY_B));
  assign commit   = wr_feed && key_b && armed;
  assign drop_o   = commit && ((cfg_sh != cfg_o) || !ctrl_sh.en);
  assign apb_wr_o = we_i && (addr_i == A_APB);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed      <= 1'b0;
      cfg_sh     <= '0;
      ctrl_sh    <= '0;
      cfg_o      <= '0;
      ctrl_o     <= '0;
      apb_code_o <= '0;
      lock_dly_o <= LOCK_W'(LOCK_DLY_RST);
    end else begin
      // any write other than the first key cancels a pending unlock
      if (we_i) armed <= wr_feed && key_a;
      if (commit) begin
        cfg_o  <= cfg_sh;
        ctrl_o <= ctrl_sh;
      end
      if (we_i && addr_i == A_CFG)  cfg_sh     <= cfg_t'(wdata_i[CFG_W-1:0]);
      if (we_i && addr_i == A_CTRL) ctrl_sh    <= ctrl_t'(wdata_i[1:0]);
      if (apb_wr_o)                 apb_code_o <= wdata_i[APB_W-1:0];
      if (we_i && addr_i == A_LDLY) lock_dly_o <= wdata_i[LOCK_W-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CFG:  rdata_o = DATA_W'(cfg_o);
      A_CTRL: rdata_o = DATA_W'(ctrl_o);
      A_STAT: rdata_o = DATA_W'({ctrl_o.conn, ctrl_o.en, sel_i, lock_i});
      A_APB:  rdata_o = DATA_W'(apb_code_o);
      A_LDLY: rdata_o = DATA_W'(lock_dly_o);
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/clk_lock_model.sv
`timescale 1ns/1ps
module clk_lock_model #(
  parameter int LOCK_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              drop_i,
  input  logic [LOCK_W-1:0] dly_i,
  output logic              lock_o
);
  logic [LOCK_W-1:0] cnt;
  logic              reached;

  assign reached = ({1'b0, cnt} + (LOCK_W+1)'(1)) >= {1'b0, dly_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt    <= '0;
      lock_o <= 1'b0;
    end else if (!en_i || drop_i) begin
      cnt    <= '0;
      lock_o <= 1'b0;
    end else if (!lock_o) begin
      if (reached) lock_o <= 1'b1;
      else         cnt    <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/clk_apb_div.sv
`timescale 1ns/1ps
module clk_apb_div
  import clk_cfg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [APB_W-1:0] code_i,
  input  logic             restart_i,
  output logic             tick_o
);
  logic [CNT_MAX_W-1:0] cnt, last;

  always_comb begin
    case (code_i)
      2'd0:    last = CNT_MAX_W'(0);
      2'd1:    last = CNT_MAX_W'(1);
      default: last = CNT_MAX_W'(3);
    endcase
  end

  assign tick_o = (cnt == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt <= '0;
    else if (restart_i)     cnt <= '0;
    else if (cnt >= last)   cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/clk_glitch_free_mux.sv
`timescale 1ns/1ps
module clk_glitch_free_mux (
  input  logic ref_clk_i,
  input  logic syn_clk_i,
  input  logic rst_ni,
  input  logic want_syn_i,
  output logic clk_o,
  output logic ref_gate_o,
  output logic syn_gate_o,
  output logic sel_o
);
  logic ref_s1, syn_s1, sel_s1;

  // reference side: open only when syn gate is seen closed
  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) ref_s1 <= 1'b1;
    else         ref_s1 <= !want_syn_i && !syn_gate_o;
  end
  always_ff @(negedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) ref_gate_o <= 1'b1;
    else         ref_gate_o <= ref_s1;
  end

  // synthesized side: open only when ref gate is seen closed
  always_ff @(posedge syn_clk_i or negedge rst_ni) begin
    if (!rst_ni) syn_s1 <= 1'b0;
    else         syn_s1 <= want_syn_i && !ref_gate_o;
  end
  always_ff @(negedge syn_clk_i or negedge rst_ni) begin
    if (!rst_ni) syn_gate_o <= 1'b0;
    else         syn_gate_o <= syn_s1;
  end

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_s1 <= 1'b0;
      sel_o  <= 1'b0;
    end else begin
      sel_s1 <= syn_gate_o;
      sel_o  <= sel_s1;
    end
  end

  assign clk_o = (ref_clk_i & ref_gate_o) | (syn_clk_i & syn_gate_o);
endmodule

// File: rtl/clk_cfg_ctrl.sv
`timescale 1ns/1ps
module clk_cfg_ctrl
  import clk_cfg_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int LOCK_W       = 8,
  parameter int LOCK_DLY_RST = 16
) (
  input  logic              ref_clk_i,
  input  logic              syn_clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic [MULT_W-1:0] mult_o,
  output logic [PDIV_W-1:0] pdiv_o,
  output logic              syn_en_o,
  output logic              lock_o,
  output logic              clk_sel_o,
  output logic              sys_clk_o,
  output logic              pclk_en_o
);
  cfg_t              cfg_act;
  ctrl_t             ctrl_act;
  logic              drop, apb_wr, want_syn, ref_gate, syn_gate;
  logic [APB_W-1:0]  apb_code;
  logic [LOCK_W-1:0] lock_dly;

  clk_cfg_regs #(
    .DATA_W(DATA_W), .LOCK_W(LOCK_W), .LOCK_DLY_RST(LOCK_DLY_RST)
  ) i_regs (
    .clk_i(ref_clk_i), .rst_ni(rst_ni), .we_i(bus_we_i), .addr_i(bus_addr_i),
    .wdata_i(bus_wdata_i), .lock_i(lock_o), .sel_i(clk_sel_o), .rdata_o(bus_rdata_o),
    .cfg_o(cfg_act), .ctrl_o(ctrl_act), .drop_o(drop), .apb_code_o(apb_code),
    .apb_wr_o(apb_wr), .lock_dly_o(lock_dly)
  );

  clk_lock_model #(.LOCK_W(LOCK_W)) i_lock (
    .clk_i(ref_clk_i), .rst_ni(rst_ni), .en_i(ctrl_act.en), .drop_i(drop),
    .dly_i(lock_dly), .lock_o(lock_o)
  );

  assign want_syn = ctrl_act.en && ctrl_act.conn && lock_o;

  clk_glitch_free_mux i_mux (
    .ref_clk_i(ref_clk_i), .syn_clk_i(syn_clk_i), .rst_ni(rst_ni), .want_syn_i(want_syn),
    .clk_o(sys_clk_o), .ref_gate_o(ref_gate), .syn_gate_o(syn_gate), .sel_o(clk_sel_o)
  );

  clk_apb_div i_apb (
    .clk_i(ref_clk_i), .rst_ni(rst_ni), .code_i(apb_code), .restart_i(apb_wr),
    .tick_o(pclk_en_o)
  );

  assign mult_o   = cfg_act.mult;
  assign pdiv_o   = cfg_act.pdiv;
  assign syn_en_o = ctrl_act.en;
endmodule

// File: rtl/clk_cfg_ctrl_chk.sv
`timescale 1ns/1ps
module clk_cfg_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       bus_we_i,
  input logic [2:0] bus_addr_i,
  input logic [7:0] bus_wdata_i,
  input logic [4:0] mult_o,
  input logic [1:0] pdiv_o,
  input logic       lock_o,
  input logic       syn_en_o,
  input logic       pclk_en_o,
  input logic [1:0] apb_code,
  input logic       ref_gate,
  input logic       syn_gate
);
  AST_CFG_ONLY_ON_FEED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(mult_o) || !$stable(pdiv_o)) |->
      $past(bus_we_i && bus_addr_i == 3'd2 && bus_wdata_i == 8'h55)); // R3
  AST_LOCK_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o |-> syn_en_o); // R5
  AST_NEW_CFG_UNLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(mult_o) || !$stable(pdiv_o)) |-> !lock_o); // R6
  AST_GATES_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ref_gate && syn_gate)); // R8
  AST_RATIO1_ALWAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (apb_code == 2'd0) |-> pclk_en_o); // R9
endmodule

bind clk_cfg_ctrl clk_cfg_ctrl_chk i_chk (
  .clk_i(ref_clk_i), .rst_ni(rst_ni), .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i),
  .bus_wdata_i(bus_wdata_i), .mult_o(mult_o), .pdiv_o(pdiv_o), .lock_o(lock_o),
  .syn_en_o(syn_en_o), .pclk_en_o(pclk_en_o), .apb_code(apb_code),
  .ref_gate(ref_gate), .syn_gate(syn_gate)
);

// File: tb/test_clk_cfg_ctrl.sv
`timescale 1ns/1ps
module test_clk_cfg_ctrl;
  logic       clk = 1'b0, syn_clk = 1'b0, rst_n = 1'b0;
  logic       we = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic [4:0] mult;
  logic [1:0] pdiv;
  logic       syn_en, lock, clk_sel, sys_clk, pclk_en;

  int tests = 0, fails = 0;

  always #5 clk = ~clk;
  initial begin
    #1.3;
    forever #3 syn_clk = ~syn_clk;
  end

  clk_cfg_ctrl i_clk_cfg_ctrl (
    .ref_clk_i(clk), .syn_clk_i(syn_clk), .rst_ni(rst_n), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .mult_o(mult),
    .pdiv_o(pdiv), .syn_en_o(syn_en), .lock_o(lock), .clk_sel_o(clk_sel),
    .sys_clk_o(sys_clk), .pclk_en_o(pclk_en)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  logic [6:0] m_cfg, m_cfg_sh;
  logic [1:0] m_ctrl, m_ctrl_sh, m_apb;
  logic [7:0] m_dly;
  int m_cnt, m_pc, m_n;
  bit m_lock, m_armed, m_commit, m_drop;

  function automatic int ratio(input logic [1:0] c);
    return (c == 2'd0) ? 1 : (c == 2'd1) ? 2 : 4;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cfg = '0; m_cfg_sh = '0; m_ctrl = '0; m_ctrl_sh = '0; m_apb = '0;
      m_dly = 8'd16; m_cnt = 0; m_pc = 0; m_lock = 0; m_armed = 0;
    end else begin
      m_commit = we && addr == 3'd2 && wdata == 8'h55 && m_armed;
      m_drop   = m_commit && ((m_cfg_sh != m_cfg) || !m_ctrl_sh[0]);
      if (!m_ctrl[0] || m_drop) begin m_cnt = 0; m_lock = 0; end
      else if (!m_lock) begin
        if (m_cnt + 1 >= int'(m_dly)) m_lock = 1; else m_cnt++;
      end
      if (we && addr == 3'd4) begin m_apb = wdata[1:0]; m_pc = 0; end
      else begin m_n = ratio(m_apb); m_pc = (m_pc >= m_n - 1) ? 0 : m_pc + 1; end
      if (m_commit) begin m_cfg = m_cfg_sh; m_ctrl = m_ctrl_sh; end
      if (we) m_armed = (addr == 3'd2 && wdata == 8'hAA);
      if (we && addr == 3'd0) m_cfg_sh = wdata[6:0];
      if (we && addr == 3'd1) m_ctrl_sh = wdata[1:0];
      if (we && addr == 3'd5) m_dly = wdata;
    end
  end

  function automatic logic [7:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return {1'b0, m_cfg};
      3'd1: return {6'b0, m_ctrl};
      3'd3: return {4'b0, m_ctrl[1], m_ctrl[0], 1'b0, m_lock};
      3'd4: return {6'b0, m_apb};
      3'd5: return m_dly;
      default: return 8'h00;
    endcase
  endfunction

  int since = 0;
  bit prev_want = 0, want;
  logic [7:0] mask;

  always @(posedge clk) begin
    if (rst_n) begin
      #3;
      chk(mult == m_cfg[4:0], "R3", "mult_o", mult, m_cfg[4:0]);
      chk(pdiv == m_cfg[6:5], "R3", "pdiv_o", pdiv, m_cfg[6:5]);
      chk(syn_en == m_ctrl[0], "R2", "syn_en_o", syn_en, m_ctrl[0]);
      chk(lock == m_lock, "R5", "lock_o", lock, m_lock);
      chk(pclk_en == (m_pc == 0), "R9", "pclk_en_o", pclk_en, m_pc == 0);
      mask = (addr == 3'd3) ? 8'hFD : 8'hFF;
      chk((rdata & mask) == (exp_rd(addr) & mask), "R10", "bus_rdata_o", rdata, exp_rd(addr));
      want = (m_ctrl == 2'b11) && m_lock;
      if (want != prev_want) since = 0; else since++;
      prev_want = want;
      if (since >= 10) chk(clk_sel == want, "R7", "clk_sel_o settled", clk_sel, want);
    end
  end

  // pulse width monitor
  realtime last_t = 0, min_w = 1000;
  always @(sys_clk) begin
    if (rst_n && last_t > 0 && ($realtime - last_t) < min_w) min_w = $realtime - last_t;
    last_t = $realtime;
  end

  int sys_cnt = 0;
  always @(posedge sys_clk) sys_cnt++;

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic feed();
    wr(3'd2, 8'hAA);
    wr(3'd2, 8'h55);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sys_rate(input int lo, input int hi, input string what);
    int c0;
    c0 = sys_cnt;
    idle(20);
    chk(sys_cnt - c0 >= lo && sys_cnt - c0 <= hi, "R7", what, sys_cnt - c0, lo);
  endtask

  task automatic strobe_cnt(input logic [1:0] code, input int exp);
    int n = 0;
    wr(3'd4, {6'b0, code});
    for (int i = 0; i < 8; i++) begin
      if (pclk_en) n++;
      @(negedge clk);
    end
    chk(n == exp, "R9", "strobes in 8 cycles", n, exp);
  endtask

  initial begin
    #10000000;
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    chk(mult == 0 && pdiv == 0, "R1", "cfg after reset", {pdiv, mult}, 0);
    chk(!syn_en && !lock && !clk_sel, "R1", "ctrl/lock/sel after reset", {syn_en, lock, clk_sel}, 0);
    chk(pclk_en == 1'b1, "R1", "strobe ratio 1", pclk_en, 1);
    addr = 3'd5; #1;
    chk(rdata == 8'd16, "R1", "lock delay reset", rdata, 16);

    // R2 shadow only
    wr(3'd0, 8'h4B);
    addr = 3'd0; #1;
    chk(mult == 0 && rdata == 8'h00, "R2", "cfg before feed", rdata, 0);

    // R3 commit
    feed();
    chk(mult == 5'h0B && pdiv == 2'd2, "R3", "cfg after feed", {pdiv, mult}, 8'h4B);

    // R4 aborts
    wr(3'd0, 8'h10);
    wr(3'd2, 8'hAA); wr(3'd1, 8'h00); wr(3'd2, 8'h55);
    chk(mult == 5'h0B, "R4", "abort by other address", mult, 8'h0B);
    wr(3'd2, 8'hAA); wr(3'd2, 8'h12); wr(3'd2, 8'h55);
    chk(mult == 5'h0B, "R4", "abort by other value", mult, 8'h0B);
    wr(3'd2, 8'h55);
    chk(mult == 5'h0B, "R4", "lone second key", mult, 8'h0B);

    // R5 lock delay
    wr(3'd5, 8'd5);
    wr(3'd1, 8'h01);
    feed();
    chk(syn_en == 1'b1 && mult == 5'h10, "R3", "enable committed", {syn_en, mult}, 8'h30);
    idle(4);
    chk(lock == 1'b0, "R5", "lock before delay", lock, 0);
    idle(1);
    chk(lock == 1'b1, "R5", "lock at delay", lock, 1);

    // R6 same cfg keeps lock, R7 connect
    wr(3'd1, 8'h03);
    feed();
    chk(lock == 1'b1, "R6", "lock kept on unchanged cfg", lock, 1);
    idle(12);
    chk(clk_sel == 1'b1, "R7", "synth selected", clk_sel, 1);
    addr = 3'd3; #1;
    chk(rdata == 8'h0F, "R10", "status read", rdata, 8'h0F);
    sys_rate(32, 35, "sys_clk rate on synth");

    // R6 changed cfg drops lock
    wr(3'd0, 8'h05);
    feed();
    chk(lock == 1'b0 && mult == 5'h05, "R6", "lock dropped on new cfg", lock, 0);
    idle(5);
    chk(lock == 1'b1, "R6", "lock regained", lock, 1);

    // R5/R7 disable with connect left set
    wr(3'd1, 8'h02);
    feed();
    chk(lock == 1'b0 && syn_en == 1'b0, "R5", "lock cleared with enable", {syn_en, lock}, 0);
    idle(12);
    chk(clk_sel == 1'b0, "R7", "back on reference", clk_sel, 0);
    sys_rate(19, 21, "sys_clk rate on reference");

    // R5 delay 0 acts as 1
    wr(3'd5, 8'd0);
    wr(3'd1, 8'h03);
    feed();
    chk(lock == 1'b0, "R5", "delay 0 edge", lock, 0);
    idle(1);
    chk(lock == 1'b1, "R5", "delay 0 one cycle", lock, 1);
    idle(12);

    // R9 strobe ratios
    strobe_cnt(2'd1, 4);
    strobe_cnt(2'd2, 2);
    strobe_cnt(2'd3, 2);
    strobe_cnt(2'd0, 8);

    // R10 unused address
    addr = 3'd6; #1;
    chk(rdata == 8'h00, "R10", "unused address", rdata, 0);
    idle(2);

    chk(min_w >= 2.9, "R8", "min sys_clk phase (ps)", int'(min_w * 1000), 2900);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule